// File: doc/BRIEF.md
# Hamming-Threshold Sync Word Correlator

This block searches a serial bit stream for a 64-bit sync word and tolerates a chosen number of bit errors. Each bit that arrives with its valid strobe enters a sliding window of the most recent 64 bits. The window is compared bit by bit against a target pattern. The mismatching positions are counted, and a one-cycle correlate pulse is raised when the count is no greater than an error threshold.

A host loads the target and the threshold through two plain write ports. A downstream packet receiver uses the correlate pulse as its start-of-packet marker and can read the error count as a measure of link quality. Only the sync word part of an access code is compared. The preamble and trailer bits simply pass through the window. An optional pipeline register in the mismatch adder tree (`PIPE = 1`) adds one cycle of latency. The default is a single-cycle count, which is ample at bit rate.

Top module: `sync_correlator`

## Requirements
- R1: The window advances only on clock edges where `bit_vld` is 1; on any other edge it, `err_cnt_o` and the fill state are unchanged.
- R2: After an edge with `bit_vld` = 1, `err_cnt_o` equals the number of positions where the shifted window differs from the target, visible in the cycle right after that edge; it holds that value until the next enabled shift.
- R3: `corr_o` is 1 for exactly the one cycle after an enabled shift whose mismatch count is at most the threshold; with a threshold of 0 only an exact match qualifies; otherwise `corr_o` is 0.
- R4: `corr_o` stays 0 for the first 63 enabled shifts after reset; the 64th and later shifts may correlate.
- R5: A target write (`tgt_we` = 1) takes effect on the next enabled shift after the edge that captures it; a shift on that same edge still uses the old target.
- R6: A threshold write (`thr_we` = 1) follows the same rule as R5: a shift on the capturing edge is judged against the old threshold.
- R7: Reset clears the window to all zeros, the target to 0, the threshold to 0, the fill count, `corr_o` and `err_cnt_o`.
- R8: `err_cnt_o` ranges from 0 to 64; a threshold of 64 or more makes every full window correlate, including one with all 64 bits wrong.
- R9: Window bit 0 holds the newest bit and bit i holds the bit received i shifts earlier; target bit i is compared with window bit i, so a sync word is sent most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Shift enable: `bit_in` is a received bit this cycle |
| bit_in | input | 1 | Received serial bit |
| tgt_we | input | 1 | Target pattern write strobe |
| tgt_wdata | input | 64 | Target pattern value |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 7 | Error threshold value |
| corr_o | output | 1 | One-cycle correlate pulse |
| err_cnt_o | output | 7 | Mismatch count of the latest shifted window |

## Verification
The assertions assume that `bit_vld`, `thr_we` and `thr_wdata` are never unknown while reset is released. They also assume that each input holds one value across a whole clock period, so the threshold in force at a shift is the one captured before that edge. The bench drives every input on the falling edge and holds it until the next falling edge. The timing checks are written for the unpipelined count (`PIPE = 0`), which is the configuration the stimulus exercises. Write strobes are placed both on idle cycles and on the same edge as a shift, so both sides of the capture rule are covered.

// File: rtl/sc_pkg.sv
package sc_pkg;
    // Bits summed by one leaf of the mismatch adder tree.
    localparam int unsigned SC_GROUP_W = 8;

    // Width that can hold the values 0..n.
    function automatic int unsigned sc_count_w(input int unsigned n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/sc_window.sv
module sc_window #(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] win_next,
    output logic              full_next
);
    typedef struct packed {
        logic [WORD_W-1:0] win;
        logic [CNT_W-1:0]  fill;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        win_next  = {st_q.win[WORD_W-2:0], bit_in};
        full_next = (st_q.fill >= CNT_W'(WORD_W - 1));
        if (shift_en) begin
            st_d.win = win_next;
            if (st_q.fill != CNT_W'(WORD_W)) begin
                st_d.fill = st_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sc_popcount.sv
module sc_popcount #(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned CNT_W  = 7,
    parameter bit          PIPE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_full,
    input  logic [CNT_W-1:0]  in_thr,
    input  logic [WORD_W-1:0] win,
    input  logic [WORD_W-1:0] tgt,
    output logic              out_vld,
    output logic              out_full,
    output logic [CNT_W-1:0]  out_thr,
    output logic [CNT_W-1:0]  out_sum
);
    localparam int unsigned GRP_W  = sc_pkg::SC_GROUP_W;
    localparam int unsigned N_GRP  = (WORD_W + GRP_W - 1) / GRP_W;
    localparam int unsigned PAD_W  = N_GRP * GRP_W;
    localparam int unsigned GSUM_W = sc_pkg::sc_count_w(GRP_W);
    localparam int unsigned SUMS_W = N_GRP * GSUM_W;

    typedef struct packed {
        logic              vld;
        logic              full;
        logic [CNT_W-1:0]  thr;
        logic [SUMS_W-1:0] sums;
    } stage_t;

    function automatic logic [GSUM_W-1:0] leaf_ones(input logic [GRP_W-1:0] v);
        logic [GSUM_W-1:0] acc;
        acc = '0;
        for (int b = 0; b < GRP_W; b++) begin
            acc = acc + GSUM_W'(v[b]);
        end
        return acc;
    endfunction

    logic [PAD_W-1:0]  diff;
    logic [SUMS_W-1:0] leaf_sums;
    stage_t            stg_in, stg_out;

    assign diff = PAD_W'(win ^ tgt);

    for (genvar g = 0; g < N_GRP; g++) begin : g_leaf
        assign leaf_sums[g*GSUM_W +: GSUM_W] = leaf_ones(diff[g*GRP_W +: GRP_W]);
    end

    assign stg_in = '{vld: in_vld, full: in_full, thr: in_thr, sums: leaf_sums};

    if (PIPE) begin : g_pipe
        stage_t stg_d, stg_q;

        always_comb begin
            stg_d = stg_in;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q <= '0;
            end else begin
                stg_q <= stg_d;
            end
        end

        assign stg_out = stg_q;
    end else begin : g_comb
        assign stg_out = stg_in;
    end

    always_comb begin
        out_sum = '0;
        for (int g = 0; g < N_GRP; g++) begin
            out_sum = out_sum + CNT_W'(stg_out.sums[g*GSUM_W +: GSUM_W]);
        end
        out_vld  = stg_out.vld;
        out_full = stg_out.full;
        out_thr  = stg_out.thr;
    end
endmodule

// File: rtl/sc_decide.sv
module sc_decide #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  logic             full,
    input  logic [CNT_W-1:0] thr,
    input  logic [CNT_W-1:0] sum,
    output logic             corr,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic             corr;
        logic [CNT_W-1:0] cnt;
    } dec_st_t;

    dec_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.corr = vld && full && (sum <= thr);
        if (vld) begin
            st_d.cnt = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign corr = st_q.corr;
    assign cnt  = st_q.cnt;
endmodule

// File: rtl/sync_correlator.sv
module sync_correlator #(
    parameter int unsigned WORD_W = 64,
    parameter bit          PIPE   = 1'b0,
    localparam int unsigned CNT_W = sc_pkg::sc_count_w(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              tgt_we,
    input  logic [WORD_W-1:0] tgt_wdata,
    input  logic              thr_we,
    input  logic [CNT_W-1:0]  thr_wdata,
    output logic              corr_o,
    output logic [CNT_W-1:0]  err_cnt_o
);
    typedef struct packed {
        logic [WORD_W-1:0] tgt;
        logic [CNT_W-1:0]  thr;
    } host_st_t;

    host_st_t host_d, host_q;

    always_comb begin
        host_d = host_q;
        if (tgt_we) begin
            host_d.tgt = tgt_wdata;
        end
        if (thr_we) begin
            host_d.thr = thr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_q <= '0;
        end else begin
            host_q <= host_d;
        end
    end

    logic [WORD_W-1:0] win_next;
    logic              full_next;
    logic              pc_vld, pc_full;
    logic [CNT_W-1:0]  pc_thr, pc_sum;

    sc_window #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (bit_vld),
        .bit_in    (bit_in),
        .win_next  (win_next),
        .full_next (full_next)
    );

    sc_popcount #(.WORD_W(WORD_W), .CNT_W(CNT_W), .PIPE(PIPE)) u_popcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (bit_vld),
        .in_full  (full_next),
        .in_thr   (host_q.thr),
        .win      (win_next),
        .tgt      (host_q.tgt),
        .out_vld  (pc_vld),
        .out_full (pc_full),
        .out_thr  (pc_thr),
        .out_sum  (pc_sum)
    );

    sc_decide #(.CNT_W(CNT_W)) u_decide (
        .clk   (clk),
        .rst_n (rst_n),
        .vld   (pc_vld),
        .full  (pc_full),
        .thr   (pc_thr),
        .sum   (pc_sum),
        .corr  (corr_o),
        .cnt   (err_cnt_o)
    );
endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned CNT_W  = 7,
    parameter bit          PIPE   = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_vld,
    input logic             thr_we,
    input logic [CNT_W-1:0] thr_wdata,
    input logic             corr_o,
    input logic [CNT_W-1:0] err_cnt_o
);
    logic [CNT_W-1:0] thr_sh;
    logic [CNT_W-1:0] fill_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_sh  <= '0;
            fill_sh <= '0;
        end else begin
            if (thr_we) begin
                thr_sh <= thr_wdata;
            end
            if (bit_vld && fill_sh != CNT_W'(WORD_W)) begin
                fill_sh <= fill_sh + 1'b1;
            end
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt_o <= CNT_W'(WORD_W)); // R8

    if (PIPE == 1'b0) begin : g_timing
        AST_PULSE_NEEDS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
            corr_o |-> $past(bit_vld)); // R3

        AST_CNT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(bit_vld) |-> $stable(err_cnt_o)); // R1

        AST_WITHIN_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
            corr_o |-> (err_cnt_o <= $past(thr_sh))); // R6

        AST_NO_EARLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            corr_o |-> ($past(fill_sh) >= CNT_W'(WORD_W - 1))); // R4

        AST_MATCH_NOT_MISSED: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(bit_vld) && ($past(fill_sh) >= CNT_W'(WORD_W - 1))
             && (err_cnt_o <= $past(thr_sh))) |-> corr_o); // R3
    end
endmodule

bind sync_correlator sc_checker #(
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W),
    .PIPE   (PIPE)
) u_sc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .thr_we    (thr_we),
    .thr_wdata (thr_wdata),
    .corr_o    (corr_o),
    .err_cnt_o (err_cnt_o)
);

// File: tb/sync_correlator_bench.sv
module sync_correlator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_vld = 1'b0;
    logic        bit_in = 1'b0;
    logic        tgt_we = 1'b0;
    logic [63:0] tgt_wdata = '0;
    logic        thr_we = 1'b0;
    logic [6:0]  thr_wdata = '0;
    logic        corr_o;
    logic [6:0]  err_cnt_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit          m_q[$];
    logic [63:0] m_tgt = '0;
    int          m_thr = 0;
    int          m_shifts = 0;
    bit          exp_corr = 1'b0;
    int          exp_cnt = 0;

    always #4 clk = ~clk;

    sync_correlator u_sync_correlator (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .tgt_we    (tgt_we),
        .tgt_wdata (tgt_wdata),
        .thr_we    (thr_we),
        .thr_wdata (thr_wdata),
        .corr_o    (corr_o),
        .err_cnt_o (err_cnt_o)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        chk(corr_o === exp_corr, tag, "corr_o", int'(corr_o), int'(exp_corr));
        chk(err_cnt_o === 7'(exp_cnt), tag, "err_cnt_o", int'(err_cnt_o), exp_cnt);
    endtask

    // One clock: drive at the falling edge, model the rising edge, compare at the next falling edge.
    task automatic step(input bit v, input bit b, input bit twe, input logic [63:0] tw,
                        input bit hwe, input int hw, input string tag);
        int mism;
        bit w;
        bit_vld = v; bit_in = b; tgt_we = twe; tgt_wdata = tw;
        thr_we = hwe; thr_wdata = 7'(hw);
        @(posedge clk);
        if (v) begin
            m_q.push_front(b);
            if (m_q.size() > 64) void'(m_q.pop_back());
            m_shifts++;
            mism = 0;
            for (int i = 0; i < 64; i++) begin
                w = (i < m_q.size()) ? m_q[i] : 1'b0;
                if (w != m_tgt[i]) mism++;
            end
            exp_cnt  = mism;
            exp_corr = (m_shifts >= 64) && (mism <= m_thr);
        end else begin
            exp_corr = 1'b0;
        end
        if (twe) m_tgt = tw;
        if (hwe) m_thr = hw;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic shift(input bit b, input string tag);
        step(1'b1, b, 1'b0, '0, 1'b0, 0, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 1'b0, '0, 1'b0, 0, tag);
    endtask

    task automatic feed(input logic [63:0] word, input string tag);
        for (int i = 63; i >= 0; i--) shift(word[i], tag);
    endtask

    task automatic do_reset(input string tag);
        bit_vld = 1'b0; tgt_we = 1'b0; thr_we = 1'b0;
        rst_n = 1'b0;
        m_q.delete();
        m_tgt = '0; m_thr = 0; m_shifts = 0; exp_corr = 1'b0; exp_cnt = 0;
        repeat (2) @(negedge clk);
        compare(tag);
        rst_n = 1'b1;
        @(negedge clk);
        compare(tag);
    endtask

    localparam logic [63:0] SYNC_A = 64'hA5C3_0F1E_7B29_D486;
    localparam logic [63:0] SYNC_B = 64'h3C96_E14B_58D2_0A7F;

    initial begin
        // R7: reset state; target 0 and threshold 0 make 64 zeros an exact match
        do_reset("R7");
        for (int i = 0; i < 63; i++) shift(1'b0, "R4");
        shift(1'b0, "R7");

        // R9: newest bit lands in bit 0
        step(1'b0, 1'b0, 1'b1, 64'h1, 1'b0, 0, "R5");
        shift(1'b1, "R9");
        shift(1'b0, "R9");

        // R8: all 64 bits wrong with threshold 64
        step(1'b0, 1'b0, 1'b1, '1, 1'b1, 64, "R6");
        feed(64'h0, "R8");
        idle("R1");

        // R3: exact match demanded with threshold 0
        step(1'b0, 1'b0, 1'b1, SYNC_A, 1'b1, 0, "R3");
        feed(SYNC_A, "R3");
        feed(SYNC_A ^ 64'h0000_0100_0000_0000, "R3");

        // R3: threshold 3 accepts 3 errors, rejects 4
        step(1'b0, 1'b0, 1'b0, '0, 1'b1, 3, "R6");
        feed(SYNC_A ^ 64'h8000_0000_0010_0001, "R3");
        feed(SYNC_A ^ 64'h8000_0400_0010_0001, "R3");

        // R1/R2: stream with idle gaps
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 2) == 0) idle("R1");
            else shift(1'($urandom_range(0, 1)), "R2");
        end
        for (int i = 63; i >= 0; i--) begin
            if ($urandom_range(0, 1) == 0) idle("R1");
            shift(SYNC_A[i], "R2");
        end

        // R5: target write on the same edge as a shift
        feed(SYNC_B, "R5");
        for (int i = 0; i < 6; i++) begin
            step(1'b1, SYNC_B[63 - (i % 64)], 1'b1, SYNC_B, 1'b0, 0, "R5");
        end
        feed(SYNC_B, "R5");

        // R6: threshold write on the same edge as a shift
        step(1'b0, 1'b0, 1'b0, '0, 1'b1, 0, "R6");
        for (int i = 63; i > 0; i--) shift(SYNC_B[i] ^ (i == 20), "R6");
        step(1'b1, SYNC_B[0], 1'b0, '0, 1'b1, 5, "R6");
        feed(SYNC_B ^ 64'h0000_0000_0100_0000, "R6");

        // R4: reset mid-run restarts the fill count
        do_reset("R4");
        step(1'b0, 1'b0, 1'b0, '0, 1'b1, 64, "R4");
        for (int i = 0; i < 70; i++) shift(1'($urandom_range(0, 1)), "R4");

        // random mix of everything
        for (int i = 0; i < 600; i++) begin
            case ($urandom_range(0, 9))
                0: step(1'b1, 1'($urandom_range(0, 1)), 1'b1, {$urandom, $urandom}, 1'b0, 0, "R5");
                1: step(1'b1, 1'($urandom_range(0, 1)), 1'b0, '0, 1'b1, $urandom_range(0, 70), "R6");
                2: idle("R1");
                default: shift(1'($urandom_range(0, 1)), "R2");
            endcase
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule